// File: doc/BRIEF.md
# Actuator Settle Delay Timer

This block produces the pause a lens actuator needs between two position updates. Three configuration fields set the pause: a 3-bit damping mode code, a 3-bit clock prescale code and a 6-bit vibration timing code. The block turns them into a delay in microseconds with integer arithmetic. The vibration period grows by one tenth of a millisecond per timing step from a base of 6.3 ms. A prescale rate scales that period, and a mode multiplier scales the result.

The computed delay is always visible on an output. While the timer is idle, that output follows the configuration with one cycle of latency. A start pulse loads the delay into a down-counter. The counter steps once for each cycle in which the 1 µs tick enable is high. When the count runs out, a single-cycle done pulse marks the end of the wait. The configuration is meant to change only while the timer is idle. The delay is frozen during a countdown, so a change made by mistake during a countdown cannot disturb it.

Top module: `settle_delay_timer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `timerDone` and `timerBusy` are 0.
- R2: The prescale code selects a rate in hundredths: 0→200, 1→100, 2→50, 3→25, 4→800, 5→400. Codes 6 and 7 fall back to 100.
- R3: The mode code selects a multiplier in hundredths: 1→48, 2→70, 3→75, 5→113. Codes 0, 4, 6 and 7 fall back to 70.
- R4: `delayUs` equals ((63 + timingCode) × rate × multiplier) / 100, with the division truncated. The default setting (mode 2, prescale 1, timing 32) gives 6650.
- R5: While the timer is idle, `delayUs` shows the value computed from the configuration present at the previous clock edge.
- R6: A start pulse while idle raises `timerBusy` at the next edge. The done pulse appears at the edge that consumes the delayUs-th tick counted after the load.
- R7: Cycles with `tickUs` low do not advance the countdown, whatever the pattern of ticks.
- R8: `timerDone` is high for exactly one cycle. `timerBusy` falls at the same edge that raises it.
- R9: While busy, `delayUs` holds the loaded value even if the configuration inputs change.
- R10: A start pulse while busy neither restarts nor lengthens the countdown.
- R11: The largest setting (mode 5, prescale 4, timing 63) yields 113904 with no overflow in the arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCode | input | 3 | Damping mode code |
| prescCode | input | 3 | Clock prescale code |
| timingCode | input | 6 | Vibration timing code |
| startPulse | input | 1 | Begin a countdown (ignored when busy) |
| tickUs | input | 1 | One-microsecond tick enable |
| delayUs | output | 17 | Computed delay in microseconds |
| timerBusy | output | 1 | Countdown in progress |
| timerDone | output | 1 | Single-cycle end-of-wait pulse |

## Verification
The assertions watch several properties on every cycle:
- the done pulse never lasts a second cycle and always follows a running countdown;
- a start pulse during a countdown never drops the busy state;
- the latched delay cannot move while busy;
- the counter stays between one and the loaded delay;
- the delay never exceeds the largest value the arithmetic can produce.

Only the bench's scenarios can show that the lookup rates, multipliers and truncation are right for every configuration. The bench sweeps all 4096 configurations. They also show that the done pulse lands on exactly the delayUs-th tick under dense, sparse and alternating tick patterns, including the largest delay.

// File: rtl/settle_pkg.sv
package settle_pkg;
  localparam int CODE_W      = 3;
  localparam int TIMING_W    = 6;
  localparam int PERIOD_BASE = 63;   // 6.3 ms in tenths
  localparam int RATE_MAX    = 800;  // hundredths
  localparam int MULT_MAX    = 113;  // hundredths
  localparam int SCALE       = 100;
  localparam int RATE_DFLT   = 100;
  localparam int MULT_DFLT   = 70;

  localparam int SPAN_MAX  = PERIOD_BASE + (2 ** TIMING_W) - 1;
  localparam int PROD_MAX  = SPAN_MAX * RATE_MAX * MULT_MAX;
  localparam int DELAY_MAX = PROD_MAX / SCALE;
  localparam int SPAN_W    = $clog2(SPAN_MAX + 1);
  localparam int RATE_W    = $clog2(RATE_MAX + 1);
  localparam int MULT_W    = $clog2(MULT_MAX + 1);
  localparam int PROD_W    = $clog2(PROD_MAX + 1);
  localparam int DELAY_W   = $clog2(DELAY_MAX + 1);

  typedef struct packed {
    logic load;    // capture computed delay into counter
    logic dec;     // step counter down
    logic freeze;  // hold the visible delay
  } strobe_t;

  function automatic logic [RATE_W-1:0] rateLookup(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    rateLookup = RATE_W'(200);
      3'd1:    rateLookup = RATE_W'(100);
      3'd2:    rateLookup = RATE_W'(50);
      3'd3:    rateLookup = RATE_W'(25);
      3'd4:    rateLookup = RATE_W'(800);
      3'd5:    rateLookup = RATE_W'(400);
      default: rateLookup = RATE_W'(RATE_DFLT);
    endcase
  endfunction

  function automatic logic [MULT_W-1:0] multLookup(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    multLookup = MULT_W'(48);
      3'd2:    multLookup = MULT_W'(70);
      3'd3:    multLookup = MULT_W'(75);
      3'd5:    multLookup = MULT_W'(113);
      default: multLookup = MULT_W'(MULT_DFLT);
    endcase
  endfunction
endpackage

// File: rtl/settle_calc.sv
module settle_calc
  import settle_pkg::*;
(
  input  logic [CODE_W-1:0]   modeCode,
  input  logic [CODE_W-1:0]   prescCode,
  input  logic [TIMING_W-1:0] timingCode,
  output logic [DELAY_W-1:0]  calcDelay
);
  logic [RATE_W-1:0] rateX100;
  logic [MULT_W-1:0] multX100;
  logic [SPAN_W-1:0] span;
  logic [PROD_W-1:0] periodScaled;
  logic [PROD_W-1:0] product;

  always_comb begin
    rateX100     = rateLookup(prescCode);
    multX100     = multLookup(modeCode);
    span         = SPAN_W'(PERIOD_BASE) + SPAN_W'(timingCode);
    periodScaled = PROD_W'(span) * PROD_W'(rateX100);
    product      = periodScaled * PROD_W'(multX100);
    calcDelay    = DELAY_W'(product / PROD_W'(SCALE));
  end
endmodule

// File: rtl/settle_ctrl.sv
module settle_ctrl
  import settle_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    tickUs,
  input  logic    cntLast,
  output strobe_t strb,
  output logic    timerBusy,
  output logic    timerDone
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t stateQ, stateD;
  logic   doneD;

  always_comb begin
    strb        = '0;
    stateD      = stateQ;
    doneD       = 1'b0;
    strb.freeze = (stateQ == ST_RUN);
    case (stateQ)
      ST_IDLE: if (startPulse) begin
        strb.load = 1'b1;
        stateD    = ST_RUN;
      end
      ST_RUN: if (tickUs) begin
        if (cntLast) begin
          stateD = ST_IDLE;
          doneD  = 1'b1;
        end else begin
          strb.dec = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      timerDone <= 1'b0;
    end else begin
      stateQ    <= stateD;
      timerDone <= doneD;
    end
  end

  assign timerBusy = (stateQ == ST_RUN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    timerDone |=> !timerDone); // R8
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerDone) |-> (!timerBusy && $past(timerBusy))); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (timerBusy && startPulse && !tickUs) |=> timerBusy); // R10
endmodule

// File: rtl/settle_dpath.sv
module settle_dpath
  import settle_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DELAY_W-1:0] calcDelay,
  output logic [DELAY_W-1:0] delayQ,
  output logic               cntLast
);
  logic [DELAY_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayQ <= '0;
      cntQ   <= '0;
    end else begin
      if (!strb.freeze) delayQ <= calcDelay;
      if (strb.load)      cntQ <= calcDelay;
      else if (strb.dec)  cntQ <= cntQ - 1'b1;
    end
  end

  assign cntLast = (cntQ == DELAY_W'(1));

  AST_DELAY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.freeze && $past(strb.freeze)) |-> $stable(delayQ)); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.freeze |-> (cntQ != '0 && cntQ <= delayQ)); // R6
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (calcDelay != '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    32'(delayQ) <= DELAY_MAX); // R11
endmodule

// File: rtl/settle_delay_timer.sv
module settle_delay_timer
  import settle_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [CODE_W-1:0]   modeCode,
  input  logic [CODE_W-1:0]   prescCode,
  input  logic [TIMING_W-1:0] timingCode,
  input  logic                startPulse,
  input  logic                tickUs,
  output logic [DELAY_W-1:0]  delayUs,
  output logic                timerBusy,
  output logic                timerDone
);
  strobe_t            strb;
  logic [DELAY_W-1:0] calcDelay;
  logic               cntLast;

  settle_calc u_calc (
    .modeCode(modeCode), .prescCode(prescCode), .timingCode(timingCode),
    .calcDelay(calcDelay)
  );

  settle_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .tickUs(tickUs),
    .cntLast(cntLast), .strb(strb), .timerBusy(timerBusy), .timerDone(timerDone)
  );

  settle_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .calcDelay(calcDelay),
    .delayQ(delayUs), .cntLast(cntLast)
  );
endmodule

// File: tb/test_settle_delay_timer.sv
module test_settle_delay_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeCode = 3'd2;
  logic [2:0]  prescCode = 3'd1;
  logic [5:0]  timingCode = 6'd32;
  logic        startPulse = 1'b0;
  logic        tickUs = 1'b0;
  logic [16:0] delayUs;
  logic        timerBusy, timerDone;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  settle_delay_timer i_settle_delay_timer (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .prescCode(prescCode),
    .timingCode(timingCode), .startPulse(startPulse), .tickUs(tickUs),
    .delayUs(delayUs), .timerBusy(timerBusy), .timerDone(timerDone)
  );

  function automatic int rateOf(input int p);
    case (p)
      0: return 200; 1: return 100; 2: return 50;
      3: return 25;  4: return 800; 5: return 400;
      default: return 100;
    endcase
  endfunction

  function automatic int multOf(input int m);
    case (m)
      1: return 48; 2: return 70; 3: return 75; 5: return 113;
      default: return 70;
    endcase
  endfunction

  function automatic int expDelay(input int m, input int p, input int t);
    return ((63 + t) * rateOf(p) * multOf(m)) / 100;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog: actual=%0d expected=<190000 cycles", cycles);
      finishRun();
    end
  end

  // Countdown scenario; disturb injects a start pulse and config change mid-count.
  task automatic runCount(input int m, input int p, input int t, input int period, input bit disturb);
    int exp = expDelay(m, p, t);
    int ticks = 0;
    int k = 0;
    @(negedge clk);
    modeCode = 3'(m); prescCode = 3'(p); timingCode = 6'(t);
    @(negedge clk);
    check(int'(delayUs) == exp, "R4 delay before load", int'(delayUs), exp);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(timerBusy == 1'b1, "R6 busy after start", int'(timerBusy), 1);
    forever begin
      tickUs = ((k % period) == 0);
      if (disturb && k == 5) begin
        startPulse = 1'b1;
        modeCode = 3'd5; prescCode = 3'd0; timingCode = 6'd10;
      end
      if (disturb && k == 7) startPulse = 1'b0;
      @(negedge clk);
      if (tickUs) ticks++;
      k++;
      if (disturb && k == 20)
        check(int'(delayUs) == exp, "R9 delay frozen while busy", int'(delayUs), exp);
      if (timerDone) break;
    end
    tickUs = 1'b0;
    startPulse = 1'b0;
    check(ticks == exp, disturb ? "R10 start while busy ignored" : "R6 R7 ticks to done", ticks, exp);
    check(timerBusy == 1'b0, "R8 busy falls with done", int'(timerBusy), 0);
    @(negedge clk);
    check(timerDone == 1'b0, "R8 done one cycle", int'(timerDone), 0);
    if (disturb)
      check(int'(delayUs) == expDelay(5, 0, 10), "R5 tracks config after idle",
            int'(delayUs), expDelay(5, 0, 10));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(timerDone == 1'b0 && timerBusy == 1'b0, "R1 reset outputs", int'({timerBusy, timerDone}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(timerDone == 1'b0 && timerBusy == 1'b0, "R1 after reset", int'({timerBusy, timerDone}), 0);
    check(int'(delayUs) == 6650, "R4 default setting", int'(delayUs), 6650);

    // Exhaustive sweep of every configuration (R2 R3 R4 R5)
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 8; p++)
        for (int t = 0; t < 64; t++) begin
          modeCode = 3'(m); prescCode = 3'(p); timingCode = 6'(t);
          @(negedge clk);
          check(int'(delayUs) == expDelay(m, p, t),
                (p > 5) ? "R2 prescale fallback" :
                ((m == 0 || m == 4 || m > 5) ? "R3 mode fallback" : "R4 R5 delay sweep"),
                int'(delayUs), expDelay(m, p, t));
        end

    modeCode = 3'd5; prescCode = 3'd4; timingCode = 6'd63;
    @(negedge clk);
    check(int'(delayUs) == 113904, "R11 largest delay", int'(delayUs), 113904);

    runCount(1, 3, 0, 1, 1'b0);   // 756 ticks, every cycle
    runCount(3, 2, 0, 2, 1'b0);   // alternating ticks (R7)
    runCount(2, 3, 5, 3, 1'b1);   // sparse ticks with disturbance (R9 R10)
    runCount(5, 4, 63, 1, 1'b0);  // largest countdown (R11)
    finishRun();
  end
endmodule